// File: doc/BRIEF.md
# Status-Capturing JTAG Test Access Port

This block is an IEEE 1149.1 test access port for a configuration-memory device. The sixteen-state TAP controller runs on TCK and steers TDI and TDO through either a 16-bit instruction register or one of three data registers. The data registers are a one-bit bypass, a fixed 32-bit identification code, and a 32-bit user code. When the instruction register is captured, it loads a snapshot of device status instead of a constant. This lets a boundary-scan host poll the health of erase, program and in-system-configuration operations with nothing more than instruction scans.

Two instructions act on the rest of the system. The output-float instruction raises an output-disable line for as long as it is the active instruction. The configure instruction, once it is loaded on Update-IR, sends a single active-low pulse of a fixed number of system-clock cycles on `cf_n`. That pulse restarts whatever logic is attached to the line. Its width is a parameter. At the default of 80 cycles of a 200 MHz clock it lasts 400 ns, which sits inside a 300 to 500 ns window.

Top module: `jtag_status_tap`

## Requirements
- R1: Five consecutive TCK rising edges with TMS high bring the controller into Test-Logic-Reset from any state. Test-Logic-Reset makes the identification instruction (0x00FE) the active one, so a following data scan returns the identification code.
- R2: The instruction register is 16 bits and shifts least significant bit first. On Capture-IR it loads: bits [15:9] = 0; [8:7] = 10 if `isc_pass` else 01; [6:5] = 10 if `prog_pass` else 01; [4] = NOT `prog_busy`; [3] = `isc_mode`; [2] = `rev_done`; [1:0] = 01.
- R3: Opcode 0x00FE selects a 32-bit register that captures {version[31:28], family[27:20], product[19:12], manufacturer[11:1], 1}. With defaults this is 0x35059093. TDI has no effect on the value shifted out.
- R4: Opcode 0x00FD selects a 32-bit register that captures `usercode` when `usercode_set` is high and 0xFFFFFFFF otherwise.
- R5: Every opcode other than 0x00FE and 0x00FD selects a one-bit bypass register that captures 0. A 32-bit data scan of pattern P therefore returns {P[30:0], 0}.
- R6: `out_disable` is high exactly while 0x00FC is the active instruction. Loading any other instruction, or Test-Logic-Reset, clears it.
- R7: Each Update-IR that loads 0x00EE drives `cf_n` low once, for exactly CF_CYCLES `clk` cycles. Loading any other opcode leaves `cf_n` high.
- R8: TDO changes only on the falling edge of TCK and presents the low bit of the selected register. `tdo_en` is high only while in Shift-IR or Shift-DR.
- R9: While `rst_n` is low, the controller is held in Test-Logic-Reset with the identification instruction active, `cf_n` high, `out_disable` low and `tdo_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the configure pulse |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| isc_pass | input | 1 | Last in-system-configuration operation succeeded |
| prog_pass | input | 1 | Last erase or program operation succeeded |
| prog_busy | input | 1 | Erase or program operation in progress |
| isc_mode | input | 1 | Device is in in-system-configuration mode |
| rev_done | input | 1 | Selected revision is fully programmed |
| usercode_set | input | 1 | User code has been programmed |
| usercode | input | 32 | Programmed user code |
| tdo | output | 1 | Test data out, updated on falling TCK |
| tdo_en | output | 1 | TDO driver enable, high in shift states |
| out_disable | output | 1 | Float request to the device outputs |
| cf_n | output | 1 | Active-low configure pulse |

## Verification
The capture snapshot is scanned under three status combinations. Each combination flips both two-bit codes and the single-bit flags in a different way, so a swapped or inverted field shows up. The data path is exercised across a table of opcodes with distinct TDI patterns. A single set bit at each end of the pattern separates the one-bit bypass from a 32-bit path, and an identification scan under a non-zero pattern shows that TDI is ignored. The configure pulse is measured in system-clock cycles and counted as edges, alongside a non-configure load that must produce no pulse. A reset issued from the middle of a shift confirms that the identification instruction returns.

// File: rtl/jtag_status_tap.sv
`timescale 1ns/1ps
module jtag_status_tap #(
  parameter int IR_W = 16,
  parameter int CF_CYCLES = 80,
  parameter logic [3:0]  ID_VER  = 4'h3,
  parameter logic [7:0]  ID_FAM  = 8'h50,
  parameter logic [7:0]  ID_PART = 8'h59,
  parameter logic [10:0] ID_MFR  = 11'h049,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 'h00FC,
  parameter logic [IR_W-1:0] OP_IDCODE = 'h00FE,
  parameter logic [IR_W-1:0] OP_USER   = 'h00FD,
  parameter logic [IR_W-1:0] OP_CONFIG = 'h00EE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tck,
  input  logic        tms,
  input  logic        tdi,
  input  logic        isc_pass,
  input  logic        prog_pass,
  input  logic        prog_busy,
  input  logic        isc_mode,
  input  logic        rev_done,
  input  logic        usercode_set,
  input  logic [31:0] usercode,
  output logic        tdo,
  output logic        tdo_en,
  output logic        out_disable,
  output logic        cf_n
);
  localparam int DR_W = 32;
  localparam logic [DR_W-1:0] ID_VAL = {ID_VER, ID_FAM, ID_PART, ID_MFR, 1'b1};
  localparam int CNT_W = $clog2(CF_CYCLES + 1);

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_t;

  tap_t state, nxt;
  logic [IR_W-1:0] ir, ir_sr;
  logic [DR_W-1:0] dr_sr;
  logic            cfg_tgl;
  logic [2:0]      sync;
  logic [CNT_W-1:0] cnt;
  logic            load;

  wire long_sel = (ir == OP_IDCODE) || (ir == OP_USER);
  wire [IR_W-1:0] ir_cap = {{(IR_W-9){1'b0}}, isc_pass, ~isc_pass, prog_pass, ~prog_pass,
                            ~prog_busy, isc_mode, rev_done, 2'b01};

  always_comb begin
    case (state)
      TLR:     nxt = tms ? TLR    : RTI;
      RTI:     nxt = tms ? SEL_DR : RTI;
      SEL_DR:  nxt = tms ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms ? SEL_DR : RTI;
      SEL_IR:  nxt = tms ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n)
    if (!rst_n) state <= TLR;
    else        state <= nxt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr   <= '0;
      ir      <= OP_IDCODE;
      cfg_tgl <= 1'b0;
    end else begin
      case (state)
        TLR:    ir    <= OP_IDCODE;
        CAP_IR: ir_sr <= ir_cap;
        SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        UPD_IR: begin
          ir <= ir_sr;
          if (ir_sr == OP_CONFIG) cfg_tgl <= ~cfg_tgl;
        end
        default: ;
      endcase
    end
  end

  // R1
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!rst_n)
    state == TLR |=> ir == OP_IDCODE);
  // R2
  cap_ir_tail_chk: assert property (@(posedge tck) disable iff (!rst_n)
    state == CAP_IR |=> ir_sr[1:0] == 2'b01);
  // R6
  highz_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == UPD_IR && ir_sr == OP_HIGHZ) |=> out_disable);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) dr_sr <= '0;
    else if (state == CAP_DR) begin
      if (ir == OP_IDCODE)    dr_sr <= ID_VAL;
      else if (ir == OP_USER) dr_sr <= usercode_set ? usercode : '1;
      else                    dr_sr <= '0;
    end else if (state == SH_DR) begin
      if (long_sel) dr_sr    <= {tdi, dr_sr[DR_W-1:1]};
      else          dr_sr[0] <= tdi;
    end
  end

  // R5
  bypass_cap_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == CAP_DR && !long_sel) |=> dr_sr[0] == 1'b0);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (state == SH_IR) || (state == SH_DR);
      if (state == SH_IR)      tdo <= ir_sr[0];
      else if (state == SH_DR) tdo <= dr_sr[0];
    end
  end

  assign out_disable = (ir == OP_HIGHZ);

  assign load = (sync[2] ^ sync[1]) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      cnt  <= '0;
      cf_n <= 1'b1;
    end else begin
      sync <= {sync[1:0], cfg_tgl};
      if (load)            cnt <= CNT_W'(CF_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
      cf_n <= !(load || cnt > CNT_W'(1));
    end
  end

  // R7
  cf_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cf_n) |=> !cf_n);
  // R7
  cf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && sync[2] == sync[1]) |=> cf_n);
endmodule

// File: tb/test_jtag_status_tap.sv
`timescale 1ns/1ps
module test_jtag_status_tap;
  logic clk = 1'b0, rst_n = 1'b0, tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic isc_pass = 0, prog_pass = 0, prog_busy = 0, isc_mode = 0, rev_done = 0;
  logic usercode_set = 0;
  logic [31:0] usercode = 32'hC0DE1234;
  logic tdo, tdo_en, out_disable, cf_n;

  int n_run = 0, n_fail = 0;
  int cf_low = 0, cf_falls = 0;
  logic cf_prev = 1'b1;
  logic en_seen;

  localparam logic [31:0] EXP_ID = {4'h3, 8'h50, 8'h59, 11'h049, 1'b1};

  jtag_status_tap i_jtag_status_tap (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .isc_pass(isc_pass), .prog_pass(prog_pass), .prog_busy(prog_busy),
    .isc_mode(isc_mode), .rev_done(rev_done),
    .usercode_set(usercode_set), .usercode(usercode),
    .tdo(tdo), .tdo_en(tdo_en), .out_disable(out_disable), .cf_n(cf_n));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (!cf_n) cf_low++;
    if (cf_prev && !cf_n) cf_falls++;
    cf_prev <= cf_n;
  end

  // opcode, TDI pattern, expected data scan
  localparam logic [79:0] VEC [7] = '{
    {16'h00FE, 32'h00000000, 32'h35059093},  // R3
    {16'h00FD, 32'h00000000, 32'hFFFFFFFF},  // R4
    {16'h0000, 32'hA5A51234, 32'h4B4A2468},  // R5
    {16'hFFFF, 32'h00000001, 32'h00000002},  // R5
    {16'h00FC, 32'hFFFFFFFF, 32'hFFFFFFFE},  // R5
    {16'h00EF, 32'h80000000, 32'h00000000},  // R5
    {16'h00FE, 32'h12345678, 32'h35059093}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic m, input logic d);
    tms = m; tdi = d;
    #5 tck = 1'b1;
    #20 tck = 1'b0;
    #15;
  endtask

  task automatic tap_reset();
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b0);
  endtask

  task automatic shift_ir(input logic [15:0] op, output logic [15:0] cap);
    pulse(1'b1, 1'b0); pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b0);
    en_seen = 1'b1;
    for (int i = 0; i < 16; i++) begin
      cap[i] = tdo;
      en_seen &= tdo_en;
      pulse(i == 15, op[i]);
    end
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);
  endtask

  task automatic shift_dr(input logic [31:0] pat, output logic [31:0] res);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b0);
    en_seen = 1'b1;
    for (int i = 0; i < 32; i++) begin
      res[i] = tdo;
      en_seen &= tdo_en;
      pulse(i == 31, pat[i]);
    end
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b0);
  endtask

  function automatic logic [15:0] cap_exp(input logic ip, pp, busy, mode, done);
    return {7'b0, ip ? 2'b10 : 2'b01, pp ? 2'b10 : 2'b01, ~busy, mode, done, 2'b01};
  endfunction

  task automatic set_status(input logic ip, pp, busy, mode, done);
    isc_pass = ip; prog_pass = pp; prog_busy = busy; isc_mode = mode; rev_done = done;
  endtask

  initial begin
    #500_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] cap;
    logic [31:0] res;
    int low0, fall0;
    #52 rst_n = 1'b1;
    #20;
    // R9 reset state
    chk("R9 cf_n", {31'b0, cf_n}, 32'd1);
    chk("R9 out_disable", {31'b0, out_disable}, 32'd0);
    chk("R9 tdo_en", {31'b0, tdo_en}, 32'd0);
    pulse(1'b0, 1'b0);
    shift_dr(32'h0, res);
    chk("R9 idcode after reset", res, EXP_ID);
    chk("R8 tdo_en in shift", {31'b0, en_seen}, 32'd1);
    chk("R8 tdo_en idle", {31'b0, tdo_en}, 32'd0);

    // R2 capture snapshots
    set_status(1, 1, 0, 1, 1);
    shift_ir(16'h00FE, cap);
    chk("R2 capture A", {16'b0, cap}, {16'b0, cap_exp(1, 1, 0, 1, 1)});
    set_status(0, 0, 1, 0, 0);
    shift_ir(16'h00FE, cap);
    chk("R2 capture B", {16'b0, cap}, {16'b0, cap_exp(0, 0, 1, 0, 0)});
    set_status(1, 0, 0, 0, 1);
    shift_ir(16'h00FE, cap);
    chk("R2 capture C", {16'b0, cap}, {16'b0, cap_exp(1, 0, 0, 0, 1)});
    chk("R8 tdo_en in IR shift", {31'b0, en_seen}, 32'd1);

    for (int v = 0; v < 7; v++) begin
      shift_ir(VEC[v][79:64], cap);
      shift_dr(VEC[v][63:32], res);
      chk($sformatf("R3/R4/R5 vector %0d", v), res, VEC[v][31:0]);
    end

    usercode_set = 1'b1;
    shift_ir(16'h00FD, cap);
    shift_dr(32'h0, res);
    chk("R4 programmed usercode", res, 32'hC0DE1234);

    shift_ir(16'h00FC, cap);
    chk("R6 highz active", {31'b0, out_disable}, 32'd1);
    shift_ir(16'h00FE, cap);
    chk("R6 highz cleared by load", {31'b0, out_disable}, 32'd0);
    shift_ir(16'h00FC, cap);
    tap_reset();
    chk("R6 highz cleared by reset", {31'b0, out_disable}, 32'd0);

    // R1 reset from mid-shift
    shift_ir(16'h00FD, cap);
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b0); pulse(1'b0, 1'b1);
    tap_reset();
    shift_dr(32'h0, res);
    chk("R1 reset from shift", res, EXP_ID);

    // R7 configure pulse
    low0 = cf_low; fall0 = cf_falls;
    shift_ir(16'h00EE, cap);
    repeat (200) @(negedge clk);
    chk("R7 pulse width", cf_low - low0, 80);
    chk("R7 pulse count", cf_falls - fall0, 1);
    chk("R7 cf_n released", {31'b0, cf_n}, 32'd1);
    low0 = cf_low; fall0 = cf_falls;
    shift_ir(16'h00FE, cap);
    repeat (200) @(negedge clk);
    chk("R7 no pulse for other opcode", cf_falls - fall0, 0);
    shift_ir(16'h00EE, cap);
    repeat (200) @(negedge clk);
    chk("R7 second pulse width", cf_low - low0, 80);
    chk("R7 second pulse count", cf_falls - fall0, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule